// File: doc/BRIEF.md
# Staged Over-Temperature Alarm

This block watches a signed digital temperature sample, expressed in thousandths of a degree Celsius, and sorts it into one of four over-temperature stages, 0 through 3. Each stage boundary is one of three trip points. Software picks one of four trip-point rows by writing a 2-bit selector. The block reports the stage in a status register and drives an interrupt line. It also asserts a shutdown request at the upper stages unless software has set the matching override bit.

A byte-wide register port gives access to the registers. It holds read-only identification bytes, the status byte, a shutdown-control byte and an alarm-control byte. Reads are combinational on the address. Writes take effect at the clock edge where the write enable is high.

A `GEN` parameter picks one of two generations. The older generation (`GEN=0`) uses trip rows starting at 105/125/145 °C, reports a 2-bit stage, and gives a one-cycle interrupt pulse on every stage change. The newer generation (`GEN=1`) uses rows starting at 90/110/140 °C, reports a 3-bit state code, and holds its interrupt high whenever the stage is nonzero.

Top module: `thermAlarm`

## Requirements
- R1: Offset 0x04 reads 0x09. Offset 0x05 reads 0x08 when GEN=0 and 0x09 when GEN=1. Offset 0x01 reads the REV parameter. Writes to these three offsets change nothing.
- R2: The stage is the number of trip points that the temperature meets or exceeds. For GEN=0 with selector s, the trip points are 105000+5000·s, 125000+5000·s and 145000+5000·s. For GEN=1 they are 90000+5000·s, 110000+5000·s and 140000+5000·s. The stage register takes the value computed from the inputs present at each rising edge.
- R3: Alarm control (offset 0x46) bit 7 enables the alarm. While it is 0, the next stage is 0. Only bit 7 is stored, and other bits read 0.
- R4: Shutdown control (offset 0x40) bits [1:0] are the trip-row selector and bits [7:6] are the override bits. Bits [5:2] read 0.
- R5: When GEN=0, status (offset 0x08) bits [1:0] hold the stage and the other bits read 0.
- R6: When GEN=1, status bits [6:4] hold the state code: 0, 1, 3 or 5 for stages 0, 1, 2 and 3. The other bits read 0.
- R7: When GEN=0, the interrupt is high for exactly the one cycle after each edge where the stage changed, whether the stage rose or fell.
- R8: When GEN=1, the interrupt is high exactly while the stage is nonzero.
- R9: The shutdown request is high when the stage is 2 and bit 6 is 0, or when the stage is 3 and bit 7 is 0. It is low otherwise.
- R10: Writes to the status offset and to unmapped offsets are ignored. Reads of unmapped offsets return 0x00.
- R11: During and after reset, the stage is 0, the interrupt and shutdown request are low, and both control registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tempIn | input | TEMP_W | Signed temperature in milli-degrees Celsius |
| regAddr | input | 7 | Register offset |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write byte |
| regRdData | output | 8 | Read byte for regAddr |
| irqOut | output | 1 | Interrupt (pulse or level by GEN) |
| shdnReq | output | 1 | Shutdown request |

## Verification
The bench drives both generations side by side. It aims at samples exactly on a trip point and one below it, at the top row's last boundary, and at negative temperatures. An off-by-one comparison would leave the stage one step low at the boundary. The bench also disables the alarm while the temperature is hot. A design that failed to clear the stage would keep the shutdown request high, and the older generation would miss its falling-edge pulse. Override bits and jumps that skip stages are exercised too: a wrong override mapping or a wrong state code shows up as a shutdown-request or status mismatch. A design that latched writes to read-only or unmapped offsets is caught on readback.

// File: rtl/thermAlarmPkg.sv
package thermAlarmPkg;

  localparam int STAGES = 3;
  localparam int STAGE_W = $clog2(STAGES + 1);
  localparam int STEP_MILLI = 5000;

  localparam logic [6:0] ADDR_REV = 7'h01;
  localparam logic [6:0] ADDR_TYPE = 7'h04;
  localparam logic [6:0] ADDR_SUBTYPE = 7'h05;
  localparam logic [6:0] ADDR_STATUS = 7'h08;
  localparam logic [6:0] ADDR_SHDN = 7'h40;
  localparam logic [6:0] ADDR_ALARM = 7'h46;

  localparam logic [7:0] TYPE_CODE = 8'h09;

  typedef logic [STAGE_W-1:0] stage_t;

  // configuration strobes handed from the register side to the datapath
  typedef struct packed {
    logic [1:0] thrSel;
    logic alarmOn;
    logic [1:0] ovr;   // [0] gates stage 2, [1] gates stage 3
  } ctrlStrobes_t;

  function automatic int tripMilli(input int gen, input logic [1:0] sel, input int idx);
    int base;
    if (gen == 0) base = 105000 + idx * 20000;
    else if (idx == 2) base = 140000;
    else base = 90000 + idx * 20000;
    return base + STEP_MILLI * int'(sel);
  endfunction

  function automatic logic [2:0] stateCode(input stage_t s);
    case (s)
      stage_t'(0): return 3'd0;
      stage_t'(1): return 3'd1;
      stage_t'(2): return 3'd3;
      default: return 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/thermAlarmDatapath.sv
module thermAlarmDatapath
  import thermAlarmPkg::*;
#(
  parameter int GEN = 0,
  parameter int TEMP_W = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic signed [TEMP_W-1:0] tempIn,
  input  ctrlStrobes_t cfg,
  output stage_t stage,
  output logic irq,
  output logic shdn
);

  logic [STAGES-1:0] hit;
  stage_t stageNext;
  stage_t stageQ;
  int tempExt;

  assign tempExt = int'(tempIn);

  for (genvar g = 0; g < STAGES; g++) begin : gCmp
    assign hit[g] = tempExt >= tripMilli(GEN, cfg.thrSel, g);
  end

  always_comb begin
    stageNext = '0;
    if (cfg.alarmOn) begin
      for (int k = 0; k < STAGES; k++) begin
        stageNext = stageNext + stage_t'(hit[k]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '0;
    else stageQ <= stageNext;
  end

  if (GEN == 0) begin : gPulse
    logic pulseQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pulseQ <= 1'b0;
      else pulseQ <= (stageNext != stageQ);
    end
    assign irq = pulseQ;
  end else begin : gLevel
    assign irq = (stageQ != '0);
  end

  assign shdn = ((stageQ == stage_t'(2)) && !cfg.ovr[0]) ||
                ((stageQ == stage_t'(3)) && !cfg.ovr[1]);
  assign stage = stageQ;

endmodule

// File: rtl/thermAlarmControl.sv
module thermAlarmControl
  import thermAlarmPkg::*;
#(
  parameter int GEN = 0,
  parameter logic [7:0] REV = 8'h01
) (
  input  logic clk,
  input  logic rstN,
  input  logic [6:0] regAddr,
  input  logic regWrEn,
  input  logic [7:0] regWrData,
  input  stage_t stage,
  output logic [7:0] regRdData,
  output ctrlStrobes_t cfg
);

  localparam logic [7:0] SUBTYPE_CODE = (GEN == 0) ? 8'h08 : 8'h09;

  logic [1:0] selQ;
  logic [1:0] ovrQ;
  logic alarmOnQ;
  logic [7:0] statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
      ovrQ <= '0;
      alarmOnQ <= 1'b0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_SHDN) begin
        selQ <= regWrData[1:0];
        ovrQ <= regWrData[7:6];
      end
      if (regAddr == ADDR_ALARM) alarmOnQ <= regWrData[7];
    end
  end

  if (GEN == 0) begin : gStatOld
    assign statusByte = {{(8 - STAGE_W){1'b0}}, stage};
  end else begin : gStatNew
    assign statusByte = {1'b0, stateCode(stage), 4'b0000};
  end

  always_comb begin
    case (regAddr)
      ADDR_REV: regRdData = REV;
      ADDR_TYPE: regRdData = TYPE_CODE;
      ADDR_SUBTYPE: regRdData = SUBTYPE_CODE;
      ADDR_STATUS: regRdData = statusByte;
      ADDR_SHDN: regRdData = {ovrQ, 4'b0000, selQ};
      ADDR_ALARM: regRdData = {alarmOnQ, 7'b0};
      default: regRdData = 8'h00;
    endcase
  end

  assign cfg = '{thrSel: selQ, alarmOn: alarmOnQ, ovr: ovrQ};

endmodule

// File: rtl/thermAlarm.sv
module thermAlarm
  import thermAlarmPkg::*;
#(
  parameter int GEN = 0,
  parameter int TEMP_W = 20,
  parameter logic [7:0] REV = 8'h01
) (
  input  logic clk,
  input  logic rstN,
  input  logic signed [TEMP_W-1:0] tempIn,
  input  logic [6:0] regAddr,
  input  logic regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic irqOut,
  output logic shdnReq
);

  ctrlStrobes_t cfgW;
  stage_t stageW;

  thermAlarmControl #(.GEN(GEN), .REV(REV)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .stage(stageW), .regRdData(regRdData), .cfg(cfgW)
  );

  thermAlarmDatapath #(.GEN(GEN), .TEMP_W(TEMP_W)) u_dp (
    .clk(clk), .rstN(rstN), .tempIn(tempIn), .cfg(cfgW),
    .stage(stageW), .irq(irqOut), .shdn(shdnReq)
  );

endmodule

// File: rtl/thermAlarmChecker.sv
module thermAlarmChecker
  import thermAlarmPkg::*;
#(
  parameter int GEN = 0
) (
  input logic clk,
  input logic rstN,
  input stage_t stage,
  input logic alarmOn,
  input logic irq,
  input logic shdn,
  input logic [6:0] regAddr,
  input logic [7:0] regRdData
);

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !alarmOn |=> (stage == '0)); // R3

  AST_SHDN_HIGH_STAGE: assert property (@(posedge clk) disable iff (!rstN)
    shdn |-> (stage >= stage_t'(2))); // R9

  AST_TYPE_ID: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_TYPE) |-> (regRdData == TYPE_CODE)); // R1

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 7'h10) |-> (regRdData == 8'h00)); // R10

  if (GEN == 0) begin : gOld
    AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
      irq == (stage != $past(stage))); // R7
  end else begin : gNew
    AST_LEVEL_STATUS: assert property (@(posedge clk) disable iff (!rstN)
      (irq && regAddr == ADDR_STATUS) |-> (regRdData[6:4] != 3'd0)); // R8
  end

endmodule

bind thermAlarm thermAlarmChecker #(.GEN(GEN)) u_chk (
  .clk(clk), .rstN(rstN), .stage(stageW), .alarmOn(cfgW.alarmOn),
  .irq(irqOut), .shdn(shdnReq), .regAddr(regAddr), .regRdData(regRdData)
);

// File: tb/test_thermAlarm.sv
module test_thermAlarm;

  localparam int CLK_PERIOD = 10;
  localparam int TW = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic signed [TW-1:0] tempIn = '0;
  logic [6:0] regAddr = 7'h08;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] rdOld, rdNew;
  logic irqOld, irqNew, shdnOld, shdnNew;

  int errors = 0;
  int checks = 0;

  int mTemp = 0;
  logic [1:0] mSel = 0;
  logic [1:0] mOvr = 0;
  logic mEn = 0;
  logic [7:0] mShdn = 0;
  int c0 = 0, p0 = 0, c1 = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  thermAlarm #(.GEN(0), .TEMP_W(TW), .REV(8'h00)) i_thermAlarm (
    .clk(clk), .rstN(rstN), .tempIn(tempIn), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(rdOld), .irqOut(irqOld), .shdnReq(shdnOld)
  );

  thermAlarm #(.GEN(1), .TEMP_W(TW), .REV(8'h01)) i_thermAlarmNew (
    .clk(clk), .rstN(rstN), .tempIn(tempIn), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(rdNew), .irqOut(irqNew), .shdnReq(shdnNew)
  );

  function automatic int expStage(int gen, int t, logic [1:0] sel, logic en);
    int b0, b1, b2, n;
    if (gen == 0) begin b0 = 105000; b1 = 125000; b2 = 145000; end
    else begin b0 = 90000; b1 = 110000; b2 = 140000; end
    b0 += 5000 * int'(sel); b1 += 5000 * int'(sel); b2 += 5000 * int'(sel);
    n = 0;
    if (t >= b0) n++;
    if (t >= b1) n++;
    if (t >= b2) n++;
    return en ? n : 0;
  endfunction

  function automatic logic expShdn(int s, logic [1:0] ovr);
    return (s == 2 && !ovr[0]) || (s == 3 && !ovr[1]);
  endfunction

  function automatic logic [7:0] newStatus(int s);
    logic [2:0] code;
    code = (s == 0) ? 3'd0 : (s == 1) ? 3'd1 : (s == 2) ? 3'd3 : 3'd5;
    return {1'b0, code, 4'b0};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic setTemp(input int t);
    tempIn = t[TW-1:0];
    mTemp = t;
  endtask

  task automatic checkOutputs();
    chk(rdOld == 8'(c0), "R5 old status", rdOld, c0);
    chk(rdNew == newStatus(c1), "R6 new status", rdNew, newStatus(c1));
    chk(irqOld == (c0 != p0), "R7 old pulse", irqOld, c0 != p0);
    chk(irqNew == (c1 != 0), "R8 new level", irqNew, c1 != 0);
    chk(shdnOld == expShdn(c0, mOvr), "R9 old shutdown", shdnOld, expShdn(c0, mOvr));
    chk(shdnNew == expShdn(c1, mOvr), "R9 new shutdown", shdnNew, expShdn(c1, mOvr));
  endtask

  // one clock: optional write, model update at the edge, checks at the next falling edge
  task automatic cycle(input bit doWr, input logic [6:0] a, input logic [7:0] d);
    int e0, e1;
    regWrEn = doWr; regAddr = a; regWrData = d;
    @(posedge clk);
    e0 = expStage(0, mTemp, mSel, mEn);
    e1 = expStage(1, mTemp, mSel, mEn);
    p0 = c0; c0 = e0; c1 = e1;
    if (doWr && a == 7'h40) begin mSel = d[1:0]; mOvr = d[7:6]; mShdn = d & 8'hC3; end
    if (doWr && a == 7'h46) mEn = d[7];
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 7'h08;
    #1;
    checkOutputs();
  endtask

  task automatic readChk(input logic [6:0] a, input logic [7:0] e0, input logic [7:0] e1,
                         input string req);
    regAddr = a;
    #1;
    chk(rdOld == e0, req, rdOld, e0);
    chk(rdNew == e1, req, rdNew, e1);
    regAddr = 7'h08;
    #1;
  endtask

  task automatic tempStep(input int t);
    setTemp(t);
    cycle(0, 7'h08, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    setTemp(150000);
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk(rdOld == 8'h00 && rdNew == 8'h00, "R11 status in reset", rdOld, 0);
    chk(!irqOld && !irqNew && !shdnOld && !shdnNew, "R11 outputs in reset", irqNew, 0);
    readChk(7'h40, 8'h00, 8'h00, "R11 shutdown ctrl reset");
    readChk(7'h46, 8'h00, 8'h00, "R11 alarm ctrl reset");
    rstN = 1'b1;
    cycle(0, 7'h08, 8'h00); // alarm off: R3 stage stays 0 while hot
    cycle(0, 7'h08, 8'h00);

    // R1 identification
    readChk(7'h01, 8'h00, 8'h01, "R1 revision");
    readChk(7'h04, 8'h09, 8'h09, "R1 type");
    readChk(7'h05, 8'h08, 8'h09, "R1 subtype");
    cycle(1, 7'h04, 8'hFF);
    cycle(1, 7'h05, 8'h00);
    readChk(7'h04, 8'h09, 8'h09, "R1 type after write");
    readChk(7'h05, 8'h08, 8'h09, "R1 subtype after write");

    // R10 unmapped and status writes
    cycle(1, 7'h10, 8'hFF);
    cycle(1, 7'h08, 8'hFF);
    readChk(7'h10, 8'h00, 8'h00, "R10 unmapped read");
    readChk(7'h7F, 8'h00, 8'h00, "R10 unmapped read high");
    readChk(7'h40, 8'h00, 8'h00, "R10 shutdown ctrl untouched");

    // R3 enable, R4 field readback
    cycle(1, 7'h46, 8'hFF);
    readChk(7'h46, 8'h80, 8'h80, "R3 alarm ctrl readback");
    cycle(1, 7'h40, 8'hFF);
    readChk(7'h40, 8'hC3, 8'hC3, "R4 shutdown ctrl readback");
    cycle(0, 7'h08, 8'h00);
    cycle(1, 7'h40, 8'h00);

    // R2 boundaries, row 0
    tempStep(104999); tempStep(105000); tempStep(124999); tempStep(125000);
    tempStep(145000); tempStep(144999); tempStep(89999); tempStep(90000);
    tempStep(-40000); tempStep(160000); tempStep(0);
    // row 3
    cycle(1, 7'h40, 8'h03);
    tempStep(159999); tempStep(160000); tempStep(154999); tempStep(155000);
    // R9 overrides at high stages
    cycle(1, 7'h40, 8'h43); tempStep(140000); tempStep(170000);
    cycle(1, 7'h40, 8'h83); tempStep(140000); tempStep(170000);
    // R3 disable while hot
    cycle(1, 7'h46, 8'h00);
    cycle(0, 7'h08, 8'h00);
    cycle(1, 7'h46, 8'h80);
    cycle(0, 7'h08, 8'h00);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) cycle(1, 7'h40, 8'($urandom));
      else if (r == 1) cycle(1, 7'h46, ($urandom % 4 == 0) ? 8'h00 : 8'h80);
      else if (r == 2) tempStep(int'($urandom % 400000) - 200000);
      else tempStep(80000 + int'($urandom % 100000));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule